// File: doc/BRIEF.md
# Temperature-Indexed Oscillator Trim Lookup

This block turns a signed digital temperature reading into a rate-trim word for a real-time clock divider. Each accepted sample is scaled down by four, clamped into a 128-entry signed index window, and used to read a signed 8-bit correction from an internal table. The correction is sign-extended and added to a fixed 19-bit nominal value. The sum is then split into a 17-bit coarse rate field and a 2-bit fine rate field, which drive the divider directly.

The table is an internal register array. At reset it is seeded with a parabolic crystal-drift curve that is computed from parameters. A temperature sensor supplies one sample at a time with a one-cycle strobe. The rate fields reload by themselves after every lookup, and a one-cycle done pulse marks each reload. When the compensation enable is low, strobes are ignored and the rate fields keep their last value.

Top module: `osc_trim_lookup`

## Requirements
- R1: After reset, rate_coarse is 0x10000, rate_fine is 0 and trim_done is 0.
- R2: The table index is the 11-bit two's complement temperature arithmetically shifted right by 2, which rounds toward minus infinity (for example -3 gives -1 and -5 gives -2).
- R3: An index below -64 is clamped to -64 and an index above +63 is clamped to +63. Values in between pass through unchanged.
- R4: The table entry is read as an 8-bit two's complement value and sign-extended. The 19-bit sum 0x40000 + entry loads rate_coarse from sum bits [18:2] and rate_fine from sum bits [1:0].
- R5: A strobe sampled with comp_en high at clock edge k causes the table read at edge k, and the rate fields load at edge k+1. trim_done is high for exactly the one cycle after edge k+1.
- R6: A strobe sampled while comp_en is low causes no trim_done and no change of either rate field.
- R7: Between lookups, rate_coarse and rate_fine hold their value.
- R8: After reset, table entry i (for i from -64 to +63) holds the value 20 - floor((i-5)^2 / 16), saturated to the range -128 to +127.
- R9: Strobes on consecutive cycles each produce their own reload. trim_done then stays high for two cycles, and the fields show the first result and then the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_en | input | 1 | Compensation enable; strobes are ignored while low |
| temp_sample | input | 11 | Two's complement temperature reading |
| sample_valid | input | 1 | One-cycle strobe marking a new temperature reading |
| rate_coarse | output | 17 | Coarse rate-control field, sum bits [18:2] |
| rate_fine | output | 2 | Fine rate-control field, sum bits [1:0] |
| trim_done | output | 1 | One-cycle pulse after each rate-field reload |

## Verification
On every cycle the assertions check the following: the clamp agrees with the scaled index, trim_done follows an accepted strobe by exactly two edges, the rate fields stay stable without a done pulse, no done pulse appears after two disabled cycles, and each reload equals the nominal value plus the entry that was read. The bench scenarios are needed to show the table contents and the rounding of negative temperatures. They also cover the saturated curve ends, the ignored strobes while disabled, and back-to-back lookups, each checked against values computed independently at the ports.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  localparam int TEMP_W_DEF   = 11;
  localparam int SCALE_SH_DEF = 2;
  localparam int ADDR_W_DEF   = 7;
  localparam int ENTRY_W_DEF  = 8;
  localparam int SUM_W_DEF    = 19;
  localparam int FINE_W_DEF   = 2;
  localparam logic [SUM_W_DEF-1:0] NOMINAL_DEF = 19'h40000;

  // Drift curve shape used to seed the table at reset
  localparam int PEAK_IDX_DEF   = 5;
  localparam int PEAK_VAL_DEF   = 20;
  localparam int CURV_SHIFT_DEF = 4;

  // Parabolic crystal correction, saturated to a signed entry of entry_w bits
  function automatic int seed_delta(input int idx, input int peak_idx,
                                    input int peak_val, input int curv_shift,
                                    input int entry_w);
    int d;
    int v;
    int lo;
    int hi;
    d  = idx - peak_idx;
    v  = peak_val - ((d * d) >>> curv_shift);
    lo = -(1 <<< (entry_w - 1));
    hi = (1 <<< (entry_w - 1)) - 1;
    if (v < lo) v = lo;
    if (v > hi) v = hi;
    return v;
  endfunction

endpackage

// File: rtl/trim_index_map.sv
module trim_index_map
  import osc_trim_pkg::*;
#(
  parameter int TEMP_W   = TEMP_W_DEF,
  parameter int SCALE_SH = SCALE_SH_DEF,
  parameter int ADDR_W   = ADDR_W_DEF
) (
  input  logic signed [TEMP_W-1:0] temp_in,
  output logic signed [TEMP_W-1:0] scaled_idx,
  output logic signed [ADDR_W-1:0] clamped_idx,
  output logic        [ADDR_W-1:0] table_addr
);

  localparam logic signed [TEMP_W-1:0] IDX_MIN = -(TEMP_W'(1) <<< (ADDR_W - 1));
  localparam logic signed [TEMP_W-1:0] IDX_MAX = (TEMP_W'(1) <<< (ADDR_W - 1)) - TEMP_W'(1);

  function automatic logic signed [TEMP_W-1:0] scale_temp(input logic signed [TEMP_W-1:0] t);
    return t >>> SCALE_SH;
  endfunction

  function automatic logic signed [ADDR_W-1:0] clamp_idx(input logic signed [TEMP_W-1:0] s);
    logic signed [TEMP_W-1:0] c;
    if (s < IDX_MIN)      c = IDX_MIN;
    else if (s > IDX_MAX) c = IDX_MAX;
    else                  c = s;
    return c[ADDR_W-1:0];
  endfunction

  // Offset binary: signed index plus half the depth
  function automatic logic [ADDR_W-1:0] to_addr(input logic signed [ADDR_W-1:0] c);
    return {~c[ADDR_W-1], c[ADDR_W-2:0]};
  endfunction

  always_comb begin
    scaled_idx  = scale_temp(temp_in);
    clamped_idx = clamp_idx(scaled_idx);
    table_addr  = to_addr(clamped_idx);
  end

endmodule

// File: rtl/trim_table.sv
module trim_table
  import osc_trim_pkg::*;
#(
  parameter int ADDR_W     = ADDR_W_DEF,
  parameter int ENTRY_W    = ENTRY_W_DEF,
  parameter int PEAK_IDX   = PEAK_IDX_DEF,
  parameter int PEAK_VAL   = PEAK_VAL_DEF,
  parameter int CURV_SHIFT = CURV_SHIFT_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic        [ADDR_W-1:0]  rd_addr,
  output logic                      rd_valid,
  output logic signed [ENTRY_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;

  logic [ENTRY_W-1:0] mem [DEPTH];

  // Each entry is its own register seeded from the drift curve
  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam logic [ENTRY_W-1:0] SEED =
      ENTRY_W'(seed_delta(k - HALF, PEAK_IDX, PEAK_VAL, CURV_SHIFT, ENTRY_W));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[k] <= SEED;
      else        mem[k] <= mem[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/trim_rate_update.sv
module trim_rate_update
  import osc_trim_pkg::*;
#(
  parameter int                 ENTRY_W = ENTRY_W_DEF,
  parameter int                 SUM_W   = SUM_W_DEF,
  parameter int                 FINE_W  = FINE_W_DEF,
  parameter logic [SUM_W-1:0]   NOMINAL = NOMINAL_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic signed [ENTRY_W-1:0] delta,
  output logic [SUM_W-FINE_W-1:0]   coarse,
  output logic [FINE_W-1:0]         fine,
  output logic                      done
);

  localparam int EXT_W = SUM_W - ENTRY_W;

  function automatic logic [SUM_W-1:0] trim_sum(input logic signed [ENTRY_W-1:0] d);
    return NOMINAL + {{EXT_W{d[ENTRY_W-1]}}, d};
  endfunction

  logic [SUM_W-1:0] sum_next;

  always_comb sum_next = trim_sum(delta);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse <= NOMINAL[SUM_W-1:FINE_W];
      fine   <= NOMINAL[FINE_W-1:0];
      done   <= 1'b0;
    end else begin
      done <= load;
      if (load) begin
        coarse <= sum_next[SUM_W-1:FINE_W];
        fine   <= sum_next[FINE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/osc_trim_lookup.sv
module osc_trim_lookup
  import osc_trim_pkg::*;
#(
  parameter int               TEMP_W     = TEMP_W_DEF,
  parameter int               SCALE_SH   = SCALE_SH_DEF,
  parameter int               ADDR_W     = ADDR_W_DEF,
  parameter int               ENTRY_W    = ENTRY_W_DEF,
  parameter int               SUM_W      = SUM_W_DEF,
  parameter int               FINE_W     = FINE_W_DEF,
  parameter logic [SUM_W-1:0] NOMINAL    = NOMINAL_DEF,
  parameter int               PEAK_IDX   = PEAK_IDX_DEF,
  parameter int               PEAK_VAL   = PEAK_VAL_DEF,
  parameter int               CURV_SHIFT = CURV_SHIFT_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    comp_en,
  input  logic [TEMP_W-1:0]       temp_sample,
  input  logic                    sample_valid,
  output logic [SUM_W-FINE_W-1:0] rate_coarse,
  output logic [FINE_W-1:0]       rate_fine,
  output logic                    trim_done
);

  // Named internal events for the checker
  logic                      accept;
  logic signed [TEMP_W-1:0]  scaled_idx;
  logic signed [ADDR_W-1:0]  clamped_idx;
  logic        [ADDR_W-1:0]  table_addr;
  logic                      rd_valid;
  logic signed [ENTRY_W-1:0] rd_data;

  assign accept = comp_en & sample_valid;

  trim_index_map #(
    .TEMP_W(TEMP_W), .SCALE_SH(SCALE_SH), .ADDR_W(ADDR_W)
  ) u_index (
    .temp_in    (temp_sample),
    .scaled_idx (scaled_idx),
    .clamped_idx(clamped_idx),
    .table_addr (table_addr)
  );

  trim_table #(
    .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .PEAK_IDX(PEAK_IDX),
    .PEAK_VAL(PEAK_VAL), .CURV_SHIFT(CURV_SHIFT)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (accept),
    .rd_addr (table_addr),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  trim_rate_update #(
    .ENTRY_W(ENTRY_W), .SUM_W(SUM_W), .FINE_W(FINE_W), .NOMINAL(NOMINAL)
  ) u_update (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_valid),
    .delta (rd_data),
    .coarse(rate_coarse),
    .fine  (rate_fine),
    .done  (trim_done)
  );

endmodule

// File: rtl/osc_trim_checker.sv
module osc_trim_checker #(
  parameter int               TEMP_W  = 11,
  parameter int               ADDR_W  = 7,
  parameter int               ENTRY_W = 8,
  parameter int               SUM_W   = 19,
  parameter int               FINE_W  = 2,
  parameter logic [SUM_W-1:0] NOMINAL = 19'h40000
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      comp_en,
  input logic                      accept,
  input logic signed [TEMP_W-1:0]  scaled_idx,
  input logic signed [ADDR_W-1:0]  clamped_idx,
  input logic signed [ENTRY_W-1:0] rd_data,
  input logic [SUM_W-FINE_W-1:0]   rate_coarse,
  input logic [FINE_W-1:0]         rate_fine,
  input logic                      trim_done
);

  localparam logic signed [TEMP_W-1:0] LO = -(TEMP_W'(1) <<< (ADDR_W - 1));
  localparam logic signed [TEMP_W-1:0] HI = (TEMP_W'(1) <<< (ADDR_W - 1)) - TEMP_W'(1);

  assert_clamp_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scaled_idx >= LO && scaled_idx <= HI) |-> (clamped_idx == scaled_idx[ADDR_W-1:0]));

  assert_clamp_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scaled_idx > HI) |-> (clamped_idx == HI[ADDR_W-1:0]));

  assert_clamp_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scaled_idx < LO) |-> (clamped_idx == LO[ADDR_W-1:0]));

  assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trim_done |-> $past(accept, 2));

  assert_done_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 trim_done);

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!comp_en && !$past(comp_en)) |=> !trim_done);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !trim_done |-> ($stable(rate_coarse) && $stable(rate_fine)));

  assert_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trim_done |-> ({rate_coarse, rate_fine} ==
                   NOMINAL + SUM_W'($past(rd_data))));

endmodule

bind osc_trim_lookup osc_trim_checker #(
  .TEMP_W(TEMP_W), .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W),
  .SUM_W(SUM_W), .FINE_W(FINE_W), .NOMINAL(NOMINAL)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .comp_en    (comp_en),
  .accept     (accept),
  .scaled_idx (scaled_idx),
  .clamped_idx(clamped_idx),
  .rd_data    (rd_data),
  .rate_coarse(rate_coarse),
  .rate_fine  (rate_fine),
  .trim_done  (trim_done)
);

// File: tb/test_osc_trim_lookup.sv
module test_osc_trim_lookup;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        comp_en = 1'b0;
  logic [10:0] temp_sample = '0;
  logic        sample_valid = 1'b0;
  logic [16:0] rate_coarse;
  logic [1:0]  rate_fine;
  logic        trim_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  osc_trim_lookup i_osc_trim_lookup (
    .clk(clk), .rst_n(rst_n), .comp_en(comp_en), .temp_sample(temp_sample),
    .sample_valid(sample_valid), .rate_coarse(rate_coarse),
    .rate_fine(rate_fine), .trim_done(trim_done)
  );

  // Independent model: floor division, clamp, curve, sum split
  function automatic int model_index(input int t);
    int q;
    q = (t >= 0) ? t / 4 : -((-t + 3) / 4);
    if (q < -64) q = -64;
    if (q > 63) q = 63;
    return q;
  endfunction

  function automatic int model_entry(input int i);
    int v;
    v = 20 - ((i - 5) * (i - 5)) / 16;
    if (v < -128) v = -128;
    if (v > 127) v = 127;
    return v;
  endfunction

  function automatic int model_sum(input int t);
    return 262144 + model_entry(model_index(t));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_fields(input string req, input int sum);
    check(req, int'(rate_coarse), sum / 4);
    check(req, int'(rate_fine), sum % 4);
  endtask

  task automatic do_lookup(input string req, input int t);
    @(negedge clk);
    temp_sample  = 11'(t);
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    check({req, " R5 no early done"}, int'(trim_done), 0);
    @(negedge clk);
    check({req, " R5 done"}, int'(trim_done), 1);
    check_fields(req, model_sum(t));
    @(negedge clk);
    check({req, " R5 done one cycle"}, int'(trim_done), 0);
  endtask

  task automatic test_reset();
    check("R1 coarse", int'(rate_coarse), 'h10000);
    check("R1 fine", int'(rate_fine), 0);
    check("R1 done", int'(trim_done), 0);
  endtask

  task automatic test_main();
    do_lookup("R4 R8 index0", 0);
    do_lookup("R4 R8 peak", 20);
    do_lookup("R4 R8 mid negative", 121);
    do_lookup("R4 R8 negative idx", -80);
  endtask

  task automatic test_rounding();
    do_lookup("R2 t=-3", -3);
    do_lookup("R2 t=-5", -5);
    do_lookup("R2 t=3", 3);
  endtask

  task automatic test_clamp();
    do_lookup("R3 top", 1023);
    do_lookup("R3 bottom", -1024);
    do_lookup("R3 edge 63", 252);
    do_lookup("R3 edge -64", -256);
  endtask

  task automatic test_disabled();
    int c0;
    int f0;
    c0 = int'(rate_coarse);
    f0 = int'(rate_fine);
    @(negedge clk);
    comp_en      = 1'b0;
    temp_sample  = 11'(20);
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R6 no done", int'(trim_done), 0);
    end
    check("R6 coarse unchanged", int'(rate_coarse), c0);
    check("R6 fine unchanged", int'(rate_fine), f0);
    comp_en = 1'b1;
  endtask

  task automatic test_hold();
    int c0;
    int f0;
    do_lookup("R7 setup", 20);
    c0 = int'(rate_coarse);
    f0 = int'(rate_fine);
    repeat (6) @(negedge clk);
    check("R7 coarse hold", int'(rate_coarse), c0);
    check("R7 fine hold", int'(rate_fine), f0);
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    temp_sample  = 11'(121);
    sample_valid = 1'b1;
    @(negedge clk);
    temp_sample  = 11'(0);
    @(negedge clk);
    sample_valid = 1'b0;
    check("R9 first done", int'(trim_done), 1);
    check_fields("R9 first result", model_sum(121));
    @(negedge clk);
    check("R9 second done", int'(trim_done), 1);
    check_fields("R9 second result", model_sum(0));
    @(negedge clk);
    check("R9 done ends", int'(trim_done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    comp_en = 1'b1;
    test_main();
    test_rounding();
    test_clamp();
    test_disabled();
    test_hold();
    test_back_to_back();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule